// File: doc/BRIEF.md
# Dual-Width Line Serializer

This block turns parallel code words into one serial bit stream for a gigabit serial link. A word is either 10 or 20 bits wide, and a width-select input chooses which. Words arrive already line-encoded. The block only reorders the bits and paces them onto the line. All logic runs on one fast clock. A bit-enable input stands in for the bit-rate clock that a synthesizer would produce. One step of the bit pacing is one cycle in which that enable is high.

A rate select slows the line to one half or one quarter of the enable rate. The quarter setting exists only for narrow words. The block decides word boundaries itself. At each boundary it captures the bus and takes the pending width and rate. It also drives a square-wave word clock whose period is one word. An output enable holds the line low without stopping the shifting, so the stream picks up again on the same word grid.

Top module: `dual_width_serializer`

## Requirements
- R1: After reset, `serOut` and `wordClk` are low and stay low until the first `bitEn` pulse. That first pulse captures a word, using the width and rate present on the inputs at that moment.
- R2: In narrow mode (`wideSel`=0) the line carries bus bits 10 up to 19, bit 10 first. Bus bits 0 to 9 have no effect on the line.
- R3: In wide mode (`wideSel`=1) the line carries bus bits 0 up to 19, bit 0 first.
- R4: `rateSel` code 0 holds each line bit for one `bitEn` pulse. Code 1 holds it for two pulses. Codes 2 and 3 hold it for four pulses.
- R5: In wide mode, `rateSel` codes 2 and 3 fall back to two pulses per bit.
- R6: Words follow one another with no gap. The next word is captured on the `bitEn` pulse that ends the last bit of the current word. Bus changes between captures have no effect.
- R7: `wordClk` is high while the first half of a word's bits is on the line and low for the second half. Its period is therefore 10 bits in narrow mode and 20 bits in wide mode.
- R8: While `outEn` is low, `serOut` is held low and the shifting carries on. Raising `outEn` again at a word boundary resumes with that word's first bit.
- R9: A change of `wideSel` or `rateSel` in the middle of a word leaves that word unchanged. The new setting applies from the next word, starting at its first bit.
- R10: In cycles where `bitEn` is low, neither `serOut` nor `wordClk` changes.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Fast clock for all logic |
| rstN | input | 1 | Active-low synchronous reset |
| bitEn | input | 1 | One pulse per bit-clock period |
| wideSel | input | 1 | 1 selects 20-bit words, 0 selects 10-bit words |
| rateSel | input | 2 | 0 full rate, 1 half rate, 2 or 3 quarter rate (narrow only) |
| outEn | input | 1 | 1 drives the line, 0 holds it low |
| dataIn | input | 20 | Parallel encoded word |
| serOut | output | 1 | Serial line output |
| wordClk | output | 1 | Word-rate square wave |

## Verification
A word is captured on the clock edge where `bitEn` is high and the previous word's last bit ends. Its first bit and the high phase of `wordClk` show at the outputs right after that same edge, with no further register delay. After that, each line bit stays for exactly 1, 2 or 4 enabled edges. The bench therefore steps one clock at a time. At each falling edge it compares the outputs with the bit index and the repeat count worked out from the mode it expects. Data and mode inputs change only at falling edges, well away from the capture edge. This checks that a change made in the middle of a word shows only from the next word. Stall windows with `bitEn` low are checked on every cycle to confirm that the outputs do not move.

// File: rtl/ser_pkg.sv
package ser_pkg;
  // Largest divider exponent: quarter rate = 2^2 pulses per bit
  localparam int MAX_LOG = 2;

  typedef enum logic [1:0] {
    RATE_FULL    = 2'd0,
    RATE_HALF    = 2'd1,
    RATE_QUARTER = 2'd2,
    RATE_QALT    = 2'd3
  } rateCode_e;

  typedef struct packed {
    logic load;   // capture a new word this edge
    logic shift;  // advance one line bit this edge
    logic wide;   // width of the word being captured
  } serStrobe_t;
endpackage

// File: rtl/ser_ctrl.sv
module ser_ctrl
  import ser_pkg::*;
#(
  parameter int NARROW_W = 10
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       bitEn,
  input  logic       wideSel,
  input  logic [1:0] rateSel,
  output serStrobe_t strobe,
  output logic       wordClk
);
  localparam int WIDE_W = 2 * NARROW_W;
  localparam int IDX_W  = $clog2(WIDE_W);
  localparam int DIV_W  = MAX_LOG;

  logic             curWide;
  logic [1:0]       curLog;
  logic [IDX_W-1:0] bitIdx;
  logic [DIV_W-1:0] divCnt;
  logic [IDX_W-1:0] lastIdx;
  logic [DIV_W-1:0] divLast;
  logic [1:0]       effLog;
  logic             tick;
  logic             boundary;

  assign lastIdx  = curWide ? IDX_W'(WIDE_W - 1) : IDX_W'(NARROW_W - 1);
  assign divLast  = DIV_W'((1 << curLog) - 1);
  assign tick     = bitEn && (divCnt == divLast);
  assign boundary = tick && (bitIdx == lastIdx);

  // Quarter rate only for narrow words; wide falls back to half
  always_comb begin
    if (rateSel[1]) effLog = wideSel ? 2'd1 : 2'd2;
    else            effLog = rateSel;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      curWide <= 1'b0;
      curLog  <= 2'd0;
      bitIdx  <= IDX_W'(NARROW_W - 1);
      divCnt  <= '0;
    end else if (bitEn) begin
      if (tick) begin
        divCnt <= '0;
        if (boundary) begin
          bitIdx  <= '0;
          curWide <= wideSel;
          curLog  <= effLog;
        end else begin
          bitIdx <= bitIdx + 1'b1;
        end
      end else begin
        divCnt <= divCnt + 1'b1;
      end
    end
  end

  assign strobe.load  = boundary;
  assign strobe.shift = tick && !boundary;
  assign strobe.wide  = wideSel;

  assign wordClk = curWide ? (bitIdx < IDX_W'(NARROW_W))
                           : (bitIdx < IDX_W'(NARROW_W / 2));

  // R7
  bit_range_chk: assert property (@(posedge clk) disable iff (!rstN)
    bitIdx <= lastIdx);
  // R4
  divcnt_range_chk: assert property (@(posedge clk) disable iff (!rstN)
    divCnt <= divLast);
  // R5
  no_wide_quarter_chk: assert property (@(posedge clk) disable iff (!rstN)
    !(curWide && curLog == 2'd2));
  // R9
  mode_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    !strobe.load |=> ($stable(curWide) && $stable(curLog)));
  // R10
  idle_idx_chk: assert property (@(posedge clk) disable iff (!rstN)
    !bitEn |=> ($stable(bitIdx) && $stable(divCnt)));
endmodule

// File: rtl/ser_datapath.sv
module ser_datapath
  import ser_pkg::*;
#(
  parameter int NARROW_W = 10
) (
  input  logic                  clk,
  input  logic                  rstN,
  input  serStrobe_t            strobe,
  input  logic                  outEn,
  input  logic [2*NARROW_W-1:0] dataIn,
  output logic                  serOut
);
  localparam int WIDE_W = 2 * NARROW_W;

  logic [WIDE_W-1:0] shiftReg;
  logic [WIDE_W-1:0] loadWord;

  // Send order: LSB of shiftReg goes out first
  always_comb begin
    if (strobe.wide) loadWord = dataIn;
    else             loadWord = {{NARROW_W{1'b0}}, dataIn[WIDE_W-1:NARROW_W]};
  end

  always_ff @(posedge clk) begin
    if (!rstN)             shiftReg <= '0;
    else if (strobe.load)  shiftReg <= loadWord;
    else if (strobe.shift) shiftReg <= shiftReg >> 1;
  end

  assign serOut = outEn & shiftReg[0];

  // R3
  shift_step_chk: assert property (@(posedge clk) disable iff (!rstN)
    strobe.shift |=> (shiftReg == ($past(shiftReg) >> 1)));
  // R10
  hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    !(strobe.load || strobe.shift) |=> $stable(shiftReg));
  // R2
  narrow_fill_chk: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.load && !strobe.wide) |=> (shiftReg[WIDE_W-1:NARROW_W] == '0));
endmodule

// File: rtl/dual_width_serializer.sv
module dual_width_serializer
  import ser_pkg::*;
#(
  parameter int NARROW_W = 10
) (
  input  logic                  clk,
  input  logic                  rstN,
  input  logic                  bitEn,
  input  logic                  wideSel,
  input  logic [1:0]            rateSel,
  input  logic                  outEn,
  input  logic [2*NARROW_W-1:0] dataIn,
  output logic                  serOut,
  output logic                  wordClk
);
  serStrobe_t strobe;

  ser_ctrl #(.NARROW_W(NARROW_W)) u_ctrl (
    .clk     (clk),
    .rstN    (rstN),
    .bitEn   (bitEn),
    .wideSel (wideSel),
    .rateSel (rateSel),
    .strobe  (strobe),
    .wordClk (wordClk)
  );

  ser_datapath #(.NARROW_W(NARROW_W)) u_data (
    .clk    (clk),
    .rstN   (rstN),
    .strobe (strobe),
    .outEn  (outEn),
    .dataIn (dataIn),
    .serOut (serOut)
  );
endmodule

// File: tb/dual_width_serializer_tb.sv
`timescale 1ns/1ps
module dual_width_serializer_tb;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        bitEn = 1'b0;
  logic        wideSel = 1'b0;
  logic [1:0]  rateSel = 2'd0;
  logic        outEn = 1'b1;
  logic [19:0] dataIn = '0;
  logic        serOut;
  logic        wordClk;

  int  nTests = 0;
  int  nFails = 0;
  bit  done = 1'b0;
  logic       nextWide = 1'b0;
  logic [1:0] nextRate = 2'd0;
  int  stallAt = -1;

  always #2.5 clk = ~clk;

  dual_width_serializer u_dut (
    .clk(clk), .rstN(rstN), .bitEn(bitEn), .wideSel(wideSel),
    .rateSel(rateSel), .outEn(outEn), .dataIn(dataIn),
    .serOut(serOut), .wordClk(wordClk)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    nTests++;
    if (!ok) begin
      nFails++;
      $display("FAIL %s actual=%0d expected=%0d t=%0t", req, act, exp, $time);
    end
  endtask

  function automatic int pulsesPerBit(input bit wide, input logic [1:0] rate);
    if (rate == 2'd0) return 1;
    if (rate == 2'd1) return 2;
    return wide ? 2 : 4;
  endfunction

  // Runs one word; ew/ediv describe the mode this word must use
  task automatic runWord(input logic [19:0] w, input bit ew, input int ediv,
                         input bit oe, input string req);
    int n = ew ? 20 : 10;
    outEn  = oe;
    dataIn = w;
    for (int b = 0; b < n; b++) begin
      for (int r = 0; r < ediv; r++) begin
        logic expBit;
        @(negedge clk);
        expBit = oe & (ew ? w[b] : w[10 + b]);
        chk(serOut == expBit, req, serOut, expBit);
        chk(wordClk == (b < n / 2), "R7", wordClk, (b < n / 2));
        if (b == 1 && r == 0) begin
          wideSel = nextWide;
          rateSel = nextRate;
          dataIn  = ~w;  // R6: bus changes mid-word are ignored
        end
        if (stallAt == b && r == 0) begin
          bitEn = 1'b0;
          for (int s = 0; s < 4; s++) begin
            @(negedge clk);
            chk(serOut == expBit, "R10", serOut, expBit);
            chk(wordClk == (b < n / 2), "R10", wordClk, (b < n / 2));
          end
          bitEn = 1'b1;
        end
      end
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      nFails++;
      $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
      $display("[TB] %0d tests run, %0d failed", nTests, nFails);
      $finish;
    end
  end

  initial begin
    logic [19:0] w;
    repeat (3) @(negedge clk);
    chk(serOut == 1'b0, "R1", serOut, 0);
    chk(wordClk == 1'b0, "R1", wordClk, 0);
    rstN = 1'b1;
    dataIn = 20'hFFFFF;
    repeat (3) begin
      @(negedge clk);
      chk(serOut == 1'b0, "R1", serOut, 0);
      chk(wordClk == 1'b0, "R1", wordClk, 0);
    end

    // Sweep every width/rate code; first word captured on first pulse (R1)
    wideSel = 1'b0; rateSel = 2'd0; nextWide = 1'b0; nextRate = 2'd0;
    bitEn = 1'b1;
    for (int m = 0; m < 8; m++) begin
      bit         ew = m[2];
      logic [1:0] er = m[1:0];
      wideSel = ew; rateSel = er; nextWide = ew; nextRate = er;
      for (int k = 0; k < 3; k++) begin
        w = 20'((m * 20'h3B5D1 + k * 20'h9E37) ^ (k * 20'h55AA5));
        runWord(w, ew, pulsesPerBit(ew, er), 1'b1,
                ew ? (er[1] ? "R5" : "R3") : (er == 0 ? "R2" : "R4"));
      end
    end

    // Low half varies while high half fixed: narrow output unchanged (R2)
    wideSel = 1'b0; rateSel = 2'd0; nextWide = 1'b0; nextRate = 2'd0;
    runWord(20'hA5C00, 1'b0, 1, 1'b1, "R6");  // pending word before mode takes
    for (int k = 0; k < 4; k++)
      runWord({10'h2D3, 10'(k * 257 + 3)}, 1'b0, 1, 1'b1, "R2");

    // Output disabled for a whole word, then resumes on next word (R8)
    runWord(20'hFFFFF, 1'b0, 1, 1'b0, "R8");
    runWord(20'h6B400, 1'b0, 1, 1'b1, "R8");

    // Mid-word mode change applies only from the next word (R9)
    nextWide = 1'b1; nextRate = 2'd1;
    runWord(20'h3C700, 1'b0, 1, 1'b1, "R9");
    runWord(20'hC3A96, 1'b1, 2, 1'b1, "R9");
    nextWide = 1'b0; nextRate = 2'd2;
    runWord(20'h1E2D4, 1'b1, 2, 1'b1, "R9");
    runWord(20'h9AB00, 1'b0, 4, 1'b1, "R9");

    // Stall bitEn mid-word (R10)
    stallAt = 3;
    runWord(20'h5F300, 1'b0, 4, 1'b1, "R10");
    nextWide = 1'b1; nextRate = 2'd0;
    runWord(20'h71C00, 1'b0, 4, 1'b1, "R10");
    runWord(20'hB6D5A, 1'b1, 1, 1'b1, "R10");
    stallAt = -1;
    runWord(20'h0F0F1, 1'b1, 1, 1'b1, "R3");

    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", nTests, nFails);
    $finish;
  end
endmodule